// File: doc/BRIEF.md
# Conversion Timing Sequencer

This block is the digital control core of a 16-bit successive-approximation converter. It watches an active-low convert-start input and, on a falling edge, raises a hold command and a busy flag and counts a fixed conversion interval in system clocks. When the interval ends it copies a result word from a data input into an output register, and busy drops. The falling edge of busy tells the host that new data is ready. The analog sample/hold, the comparator and the bit-decision logic sit outside this block. The data input is a stub that stands in for the result those parts would produce.

Two mode pins select normal, fast or self-starting operation. Each mode has its own conversion length. An acquisition interval follows every conversion. In the self-starting mode, a start input that is still low when that interval expires begins the next conversion without a new edge. In the fast mode, a monitor raises a flag when the idle time after a conversion runs past a limit, because accuracy in that mode depends on a minimum conversion rate. A power-down request blocks new conversions but lets the running one finish. Reset aborts a conversion and keeps the last result.

Top module: `conv_sequencer`

## Requirements
- R1: A falling edge on `start_n`, seen at a clock edge while `busy` is low and `pdn` is low, sets `busy` and `hold` on that same clock edge.
- R2: The mode is taken from `{warp, impulse}` at the starting edge: `2'b10` is fast, `2'b01` is self-starting, and `2'b00` or `2'b11` is normal. The conversion length is CONV_WARP, CONV_IMPULSE or CONV_NORMAL respectively. `busy` stays high for exactly that many clocks. `hold` stays high for the first length-1 of those clocks.
- R3: On the clock edge where `busy` falls at the end of a conversion, `result` loads `data_in`. At every other edge `result` holds its value.
- R4: A falling edge on `start_n` while `busy` is high has no effect. It neither shortens nor lengthens the conversion, and it starts nothing after the conversion ends.
- R5: An acquisition interval of ACQ_CYC clocks begins when `busy` falls. In self-starting mode with `start_n` still low when the interval expires, `busy` rises again after exactly ACQ_CYC low clocks, and that conversion latches the `data_in` present at its end.
- R6: The automatic start does not happen when `start_n` is high at expiry. It also does not happen in any mode other than self-starting.
- R7: While `pdn` is high no conversion starts. A conversion already running completes with its full length and latches its result.
- R8: While `rst` is high, `busy`, `hold`, `rate_late` and the acquisition interval are cleared, and `result` keeps its value. A low `start_n` present when reset releases is not treated as an edge.
- R9: After a conversion ends, an idle count starts at 0 and goes up by one each clock. In fast mode, `rate_late` rises on the edge after the count reaches WARP_MAX_GAP, which is WARP_MAX_GAP+1 clocks after `busy` fell. It clears when the next conversion starts. It is never set in the other modes, and it is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Active-high reset; aborts a conversion |
| start_n | input | 1 | Convert-start, falling edge starts a conversion |
| warp | input | 1 | Mode pin selecting fast mode when alone high |
| impulse | input | 1 | Mode pin selecting self-starting mode when alone high |
| pdn | input | 1 | Power-down request, blocks new conversions |
| data_in | input | DATA_W | Stub conversion result from the bit-decision logic |
| hold | output | 1 | Hold command for the sample/hold |
| busy | output | 1 | High while a conversion runs |
| result | output | DATA_W | Latched conversion result |
| rate_late | output | 1 | Fast-mode idle gap exceeded the limit |

## Verification
The bench sweeps every mode encoding against several data patterns. It measures busy and hold lengths clock by clock, so an off-by-one in the counter load or in the hold release shows up as a wrong count. It places a second falling edge inside a conversion, and a design that re-armed on it would stretch busy or start a phantom conversion. It holds the start input low across acquisition in each mode, where a wrong expiry cycle changes the measured gap and a mode decode error starts conversions where none is due. It also checks the fast-mode flag one clock either side of its threshold. It applies power-down and reset in the middle of a conversion and of an acquisition, where a design that cut the conversion short, reloaded the result or kept a pending auto-start would be caught.

// File: rtl/convseq_pkg.sv
package convseq_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL  = 2'd0,
      MODE_WARP    = 2'd1,
      MODE_IMPULSE = 2'd2
   } conv_mode_e;

   // Fast mode and self-starting mode each need exactly one pin high;
   // both pins low or both high fall back to normal operation.
   function automatic conv_mode_e decode_mode(input logic warp_pin, input logic impulse_pin);
      conv_mode_e m;
      case ({warp_pin, impulse_pin})
         2'b10:   m = MODE_WARP;
         2'b01:   m = MODE_IMPULSE;
         default: m = MODE_NORMAL;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/convseq_fall_detect.sv
module convseq_fall_detect (
   input  logic clk,
   input  logic rst,
   input  logic din,
   output logic fall
);
   logic prev_q;

   // Reset copies the live level, so a low input at release is no edge.
   always_ff @(posedge clk) begin
      prev_q <= din;
   end

   assign fall = prev_q & ~din & ~rst;
endmodule

// File: rtl/convseq_downcnt.sv
module convseq_downcnt #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         en,
   output logic [W-1:0] count,
   output logic         zero
);
   always_ff @(posedge clk) begin
      if (rst)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (en && count != '0)
         count <= count - W'(1);
   end

   assign zero = (count == '0);
endmodule

// File: rtl/convseq_len_sel.sv
module convseq_len_sel
   import convseq_pkg::*;
#(
   parameter int W            = 4,
   parameter int CONV_NORMAL  = 12,
   parameter int CONV_WARP    = 8,
   parameter int CONV_IMPULSE = 10
) (
   input  conv_mode_e   mode,
   output logic [W-1:0] len_m1
);
   localparam logic [W-1:0] NORM_M1 = W'(CONV_NORMAL - 1);
   localparam logic [W-1:0] WARP_M1 = W'(CONV_WARP - 1);
   localparam logic [W-1:0] IMP_M1  = W'(CONV_IMPULSE - 1);

   always_comb begin
      case (mode)
         MODE_WARP:    len_m1 = WARP_M1;
         MODE_IMPULSE: len_m1 = IMP_M1;
         default:      len_m1 = NORM_M1;
      endcase
   end
endmodule

// File: rtl/convseq_gap_mon.sv
module convseq_gap_mon #(
   parameter int MAX_GAP = 40,
   parameter int GW      = 6
) (
   input  logic clk,
   input  logic rst,
   input  logic arm,
   input  logic disarm,
   input  logic fast_mode,
   output logic late
);
   localparam logic [GW-1:0] GAP_LIMIT = GW'(MAX_GAP);

   logic          armed_q;
   logic [GW-1:0] gap_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed_q <= 1'b0;
         gap_q   <= '0;
         late    <= 1'b0;
      end else if (disarm) begin
         armed_q <= 1'b0;
         gap_q   <= '0;
         late    <= 1'b0;
      end else if (arm) begin
         armed_q <= 1'b1;
         gap_q   <= '0;
      end else if (armed_q) begin
         if (gap_q != GAP_LIMIT)
            gap_q <= gap_q + GW'(1);
         if (gap_q == GAP_LIMIT && fast_mode)
            late <= 1'b1;
      end
   end
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer
   import convseq_pkg::*;
#(
   parameter int DATA_W       = 16,
   parameter int CONV_NORMAL  = 12,
   parameter int CONV_WARP    = 8,
   parameter int CONV_IMPULSE = 10,
   parameter int ACQ_CYC      = 5,
   parameter int WARP_MAX_GAP = 40
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_n,
   input  logic              warp,
   input  logic              impulse,
   input  logic              pdn,
   input  logic [DATA_W-1:0] data_in,
   output logic              hold,
   output logic              busy,
   output logic [DATA_W-1:0] result,
   output logic              rate_late
);
   localparam int MAX_A   = (CONV_NORMAL > CONV_WARP) ? CONV_NORMAL : CONV_WARP;
   localparam int MAX_B   = (MAX_A > CONV_IMPULSE) ? MAX_A : CONV_IMPULSE;
   localparam int LEN_MAX = (MAX_B > ACQ_CYC) ? MAX_B : ACQ_CYC;
   localparam int CNT_W   = $clog2(LEN_MAX + 1);
   localparam int GAP_W   = $clog2(WARP_MAX_GAP + 1);
   localparam logic [CNT_W-1:0] ACQ_M1 = CNT_W'(ACQ_CYC - 1);
   localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

   // Elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_width
      $error("conv_sequencer: DATA_W must be at least 1");
   end
   if (CONV_NORMAL < 2 || CONV_WARP < 2 || CONV_IMPULSE < 2) begin : g_bad_conv
      $error("conv_sequencer: conversion lengths must be at least 2 clocks");
   end
   if (ACQ_CYC < 1) begin : g_bad_acq
      $error("conv_sequencer: ACQ_CYC must be at least 1");
   end
   if (WARP_MAX_GAP < 1) begin : g_bad_gap
      $error("conv_sequencer: WARP_MAX_GAP must be at least 1");
   end

   conv_mode_e        mode;
   logic              start_fall;
   logic [CNT_W-1:0]  len_m1;
   logic [CNT_W-1:0]  conv_cnt;
   logic [CNT_W-1:0]  acq_cnt;
   logic              conv_zero;
   logic              acq_zero;
   logic              busy_q;
   logic              hold_q;
   logic              acq_active_q;
   logic              conv_done;
   logic              manual_go;
   logic              auto_go;
   logic              go;
   logic [DATA_W-1:0] result_q;

   assign mode = decode_mode(warp, impulse);

   convseq_fall_detect u_fall (
      .clk  (clk),
      .rst  (rst),
      .din  (start_n),
      .fall (start_fall)
   );

   convseq_len_sel #(
      .W            (CNT_W),
      .CONV_NORMAL  (CONV_NORMAL),
      .CONV_WARP    (CONV_WARP),
      .CONV_IMPULSE (CONV_IMPULSE)
   ) u_len (
      .mode   (mode),
      .len_m1 (len_m1)
   );

   // Start decisions
   assign conv_done = busy_q & conv_zero;
   assign manual_go = start_fall & ~busy_q & ~pdn;
   assign auto_go   = acq_active_q & acq_zero & (mode == MODE_IMPULSE) & ~start_n & ~pdn;
   assign go        = manual_go | auto_go;

   convseq_downcnt #(.W(CNT_W)) u_conv_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (go),
      .load_val (len_m1),
      .en       (busy_q),
      .count    (conv_cnt),
      .zero     (conv_zero)
   );

   convseq_downcnt #(.W(CNT_W)) u_acq_cnt (
      .clk      (clk),
      .rst      (rst),
      .load     (conv_done),
      .load_val (ACQ_M1),
      .en       (acq_active_q),
      .count    (acq_cnt),
      .zero     (acq_zero)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q       <= 1'b0;
         hold_q       <= 1'b0;
         acq_active_q <= 1'b0;
      end else begin
         if (go)
            busy_q <= 1'b1;
         else if (conv_done)
            busy_q <= 1'b0;

         // Hold is released one clock before busy: the last clock latches.
         if (go)
            hold_q <= 1'b1;
         else if (conv_done || (busy_q && conv_cnt == ONE))
            hold_q <= 1'b0;

         if (go)
            acq_active_q <= 1'b0;
         else if (conv_done)
            acq_active_q <= 1'b1;
         else if (acq_active_q && acq_zero)
            acq_active_q <= 1'b0;
      end
   end

   // Result register is deliberately outside reset.
   always_ff @(posedge clk) begin
      if (!rst && conv_done)
         result_q <= data_in;
   end

   convseq_gap_mon #(
      .MAX_GAP (WARP_MAX_GAP),
      .GW      (GAP_W)
   ) u_gap (
      .clk       (clk),
      .rst       (rst),
      .arm       (conv_done),
      .disarm    (go),
      .fast_mode (mode == MODE_WARP),
      .late      (rate_late)
   );

   assign busy   = busy_q;
   assign hold   = hold_q;
   assign result = result_q;
endmodule

// File: rtl/convseq_chk.sv
module convseq_chk #(
   parameter int DATA_W       = 16,
   parameter int CONV_NORMAL  = 12,
   parameter int CONV_WARP    = 8,
   parameter int CONV_IMPULSE = 10
) (
   input logic              clk,
   input logic              rst,
   input logic              warp,
   input logic              impulse,
   input logic              pdn,
   input logic              busy,
   input logic              hold,
   input logic [DATA_W-1:0] result,
   input logic              rate_late
);
   int run_cnt;
   int exp_len;

   always_ff @(posedge clk) begin
      if (rst || !busy)
         run_cnt <= 0;
      else
         run_cnt <= run_cnt + 1;
      if (!busy) begin
         if (warp && !impulse)
            exp_len <= CONV_WARP;
         else if (impulse && !warp)
            exp_len <= CONV_IMPULSE;
         else
            exp_len <= CONV_NORMAL;
      end
   end

   p_hold_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
      hold |-> busy);

   p_busy_len_r2: assert property (@(posedge clk) disable iff (rst)
      ($fell(busy) && !$past(rst)) |-> (run_cnt == exp_len));

   p_result_stable_r3: assert property (@(posedge clk) disable iff (rst)
      !$fell(busy) |-> $stable(result));

   p_pdn_blocks_r7: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> !$past(pdn));

   p_reset_clears_r8: assert property (@(posedge clk)
      rst |=> (!busy && !hold && !rate_late));

   p_late_idle_r9: assert property (@(posedge clk) disable iff (rst)
      busy |-> !rate_late);
endmodule

bind conv_sequencer convseq_chk #(
   .DATA_W       (DATA_W),
   .CONV_NORMAL  (CONV_NORMAL),
   .CONV_WARP    (CONV_WARP),
   .CONV_IMPULSE (CONV_IMPULSE)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .warp      (warp),
   .impulse   (impulse),
   .pdn       (pdn),
   .busy      (busy),
   .hold      (hold),
   .result    (result),
   .rate_late (rate_late)
);

// File: tb/sim_conv_sequencer.sv
module sim_conv_sequencer;
   localparam int DW   = 16;
   localparam int CN   = 6;
   localparam int CW   = 3;
   localparam int CI   = 4;
   localparam int ACQ  = 4;
   localparam int GMAX = 9;

   logic          clk = 1'b0;
   logic          rst;
   logic          start_n;
   logic          warp;
   logic          impulse;
   logic          pdn;
   logic [DW-1:0] data_in;
   logic          hold;
   logic          busy;
   logic [DW-1:0] result;
   logic          rate_late;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   conv_sequencer #(
      .DATA_W(DW), .CONV_NORMAL(CN), .CONV_WARP(CW), .CONV_IMPULSE(CI),
      .ACQ_CYC(ACQ), .WARP_MAX_GAP(GMAX)
   ) u0 (
      .clk(clk), .rst(rst), .start_n(start_n), .warp(warp), .impulse(impulse),
      .pdn(pdn), .data_in(data_in), .hold(hold), .busy(busy), .result(result),
      .rate_late(rate_late)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int mode_len(input logic w, input logic i);
      if (w && !i) return CW;
      if (i && !w) return CI;
      return CN;
   endfunction

   // Drives a falling edge and measures busy/hold until busy drops.
   // Returns at the first sample with busy low again.
   task automatic run_conv(input logic [DW-1:0] val, output int bcnt,
                           output int hcnt, output int first);
      @(negedge clk);
      data_in = val;
      start_n = 1'b0;
      bcnt = 0; hcnt = 0; first = -1;
      for (int g = 0; g < 60; g++) begin
         @(negedge clk);
         if (busy) begin
            if (first < 0) first = g;
            bcnt++;
         end
         if (hold) hcnt++;
         if (!busy && bcnt > 0) break;
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk("R4/R6 no spurious start", int'(busy), 0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int b, h, f, gap;
      logic [DW-1:0] prev;
      logic [DW-1:0] pats [5];
      pats[0] = 16'h0000; pats[1] = 16'hFFFF; pats[2] = 16'hA5C3;
      pats[3] = 16'h8001; pats[4] = 16'h1234;

      rst = 1'b1; start_n = 1'b1; warp = 1'b0; impulse = 1'b0;
      pdn = 1'b0; data_in = '0;
      repeat (3) @(negedge clk);
      chk("R8 reset busy", int'(busy), 0);
      chk("R8 reset hold", int'(hold), 0);
      chk("R8 reset rate_late", int'(rate_late), 0);
      rst = 1'b0;
      idle(2);

      // R1 R2 R3: sweep all four mode encodings against data patterns
      for (int m = 0; m < 4; m++) begin
         warp = m[1]; impulse = m[0];
         for (int p = 0; p < 5; p++) begin
            logic [DW-1:0] v;
            v = pats[p] ^ DW'(m * 16'h1111);
            run_conv(v, b, h, f);
            chk("R1 busy one clock after edge", f, 0);
            chk("R2 busy length", b, mode_len(warp, impulse));
            chk("R2 hold length", h, mode_len(warp, impulse) - 1);
            chk("R3 result latched", int'(result), int'(v));
            start_n = 1'b1;
            data_in = ~v;
            idle(ACQ + 2);
            chk("R3 result held", int'(result), int'(v));
         end
      end

      // R4: second falling edge inside a conversion is ignored
      warp = 1'b0; impulse = 1'b0;
      @(negedge clk); data_in = 16'h0F0F; start_n = 1'b0;
      b = 0;
      for (int g = 0; g < 40; g++) begin
         @(negedge clk);
         if (busy) b++;
         if (g == 1) start_n = 1'b1;
         if (g == 2) start_n = 1'b0;
         if (!busy && b > 0) break;
      end
      chk("R4 length unchanged by edge while busy", b, CN);
      chk("R4 result", int'(result), 16'h0F0F);
      idle(ACQ + 6);
      start_n = 1'b1;
      idle(2);

      // R5: self-starting mode restarts after exactly ACQ low clocks
      warp = 1'b0; impulse = 1'b1;
      run_conv(16'h5555, b, h, f);
      chk("R5 first conversion length", b, CI);
      data_in = 16'hC0DE;
      gap = 1;
      for (int g = 0; g < 40; g++) begin
         @(negedge clk);
         if (busy) break;
         gap++;
      end
      chk("R5 acquisition gap", gap, ACQ);
      start_n = 1'b1;
      b = 1;
      for (int g = 0; g < 40; g++) begin
         @(negedge clk);
         if (!busy) break;
         b++;
      end
      chk("R5 auto conversion length", b, CI);
      chk("R5 auto conversion result", int'(result), 16'hC0DE);
      idle(ACQ + 4);

      // R6: start released before expiry -> no auto start
      run_conv(16'h1111, b, h, f);
      start_n = 1'b1;
      idle(ACQ + 4);
      // R6: start held low in normal and fast modes -> no auto start
      impulse = 1'b0;
      for (int w = 0; w < 2; w++) begin
         warp = w[0];
         run_conv(16'h2222, b, h, f);
         idle(ACQ + 6);
         chk("R6 no auto start outside self-starting mode", int'(busy), 0);
         start_n = 1'b1;
         idle(2);
      end
      warp = 1'b0;

      // R7: power-down mid-conversion lets it finish, then blocks starts
      @(negedge clk); data_in = 16'h7E57; start_n = 1'b0;
      b = 0;
      for (int g = 0; g < 40; g++) begin
         @(negedge clk);
         if (busy) b++;
         if (g == 1) pdn = 1'b1;
         if (!busy && b > 0) break;
      end
      chk("R7 running conversion completes", b, CN);
      chk("R7 result latched under power-down", int'(result), 16'h7E57);
      start_n = 1'b1;
      idle(2);
      @(negedge clk); start_n = 1'b0;
      idle(6);
      chk("R7 start blocked", int'(busy), 0);
      start_n = 1'b1; pdn = 1'b0;
      idle(2);
      run_conv(16'h3C3C, b, h, f);
      chk("R7 start accepted after power-down", b, CN);
      start_n = 1'b1;
      idle(2);

      // R8: reset mid-conversion aborts and keeps the old result
      prev = result;
      @(negedge clk); data_in = 16'hDEAD; start_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R8 converting before reset", int'(busy), 1);
      rst = 1'b1;
      @(negedge clk);
      chk("R8 busy cleared", int'(busy), 0);
      chk("R8 hold cleared", int'(hold), 0);
      @(negedge clk); rst = 1'b0;
      idle(CN + 4);
      chk("R8 result kept", int'(result), int'(prev));
      start_n = 1'b1;
      idle(2);
      // R8: reset during acquisition drops a pending auto start
      impulse = 1'b1;
      run_conv(16'hBEEF, b, h, f);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      idle(ACQ + 6);
      chk("R8 acquisition cleared", int'(busy), 0);
      chk("R8 result after acq reset", int'(result), 16'hBEEF);
      start_n = 1'b1;
      impulse = 1'b0;
      idle(2);

      // R9: fast-mode idle flag one clock either side of its threshold
      warp = 1'b1;
      run_conv(16'h0101, b, h, f);
      start_n = 1'b1;
      repeat (GMAX) @(negedge clk);
      chk("R9 flag low at limit", int'(rate_late), 0);
      @(negedge clk);
      chk("R9 flag high past limit", int'(rate_late), 1);
      run_conv(16'h0202, b, h, f);
      chk("R9 flag cleared by new conversion", int'(rate_late), 0);
      start_n = 1'b1;
      warp = 1'b0;
      repeat (GMAX + 5) @(negedge clk);
      chk("R9 flag never set in normal mode", int'(rate_late), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule